// File: doc/BRIEF.md
# Watchdog Timer with Interrupt and Reset Modes

This block is a watchdog timer with one 8-bit control and status register. A timeout counter advances on a free-running tick from a slow oscillator. When it reaches the selected period, the block raises an interrupt, requests a system reset, or does both in turn. In the combined mode the first timeout raises an interrupt. Acknowledging that interrupt drops the block into reset behaviour, so the next timeout resets the system unless software restarts the watchdog or re-arms the interrupt first.

Software restarts the count with a restart strobe. A CPU-side acknowledge clears the pending interrupt. Two kinds of change are guarded by a timed unlock: dropping the reset enable and changing the period. First write a value with both the unlock bit and the reset-enable bit set. The write that makes the change must then follow within four clock cycles. The reset value of the reset-enable bit comes from an input pin.

Top module: `wdog_timer`

## Requirements
- R1: Under synchronous active-low reset the register reads 0x00, except bit 3, which takes the value of `rst_en_default`. `irq` and `sys_rst_req` are low.
- R2: The register reads back as bit 7 = interrupt flag, bit 6 = interrupt enable, bit 5 = period bit 3, bit 4 = unlock-window open, bit 3 = reset enable, bits 2..0 = period bits 2..0.
- R3: The timeout comes after 2^(BASE_LOG2+N) ticks, where N is the 4-bit period field. The counter advances only on cycles with `osc_tick` high.
- R4: A timeout while the interrupt enable is 1 sets the flag in the next cycle. `irq` is high exactly when the flag, the interrupt enable and `gie` are all 1.
- R5: Writing 1 to bit 7 clears the flag, and so does `irq_ack`. Writing 0 to bit 7 leaves the flag unchanged.
- R6: With the interrupt enable and the reset enable both 1, the first timeout sets the flag and requests no reset. An acknowledge while the flag is set clears both the flag and the interrupt enable. The following timeout then raises `sys_rst_req`.
- R7: With the reset enable at 1 and the interrupt enable at 0, every timeout produces a `sys_rst_req` pulse one cycle wide.
- R8: With both enables at 0 the counter is stopped and no interrupt or reset request occurs.
- R9: With the unlock window closed, writes cannot clear the reset enable and cannot change the period. A write with bits 4 and 3 both 1 opens the window for the next 4 cycles, and one write inside the window may change both. The window closes after that write or when the 4 cycles are over.
- R10: `wd_kick` and any change of the period value return the count to zero.
- R11: Period values 10 to 15 give the same timeout as 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle tick from the slow oscillator, synchronous to clk |
| wd_kick | input | 1 | Restart strobe; zeroes the timeout count |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| rst_en_default | input | 1 | Reset value of the reset-enable bit |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Interrupt request |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
A register write shows up in `reg_rdata` right after the clock edge that takes it. `irq` follows `gie` within the same cycle. The flag sets, or `sys_rst_req` pulses, on the clock edge that comes 2^(BASE_LOG2+N) ticked cycles after the edge that zeroed the count: a restart, a period change, or the enable being set from a stopped state. The bench drives every input and samples every output one nanosecond after a rising edge. Each timing task waits exactly one cycle short of the due edge and checks that nothing has happened yet, then steps once more and checks that the event has arrived. Pulse widths are checked on the cycle that follows.

// File: rtl/wdog_pkg.sv
// Package: bit positions of the watchdog control register and the
// constants shared by the watchdog modules.
package wdog_pkg;
    localparam int BIT_FLAG   = 7;
    localparam int BIT_IE     = 6;
    localparam int BIT_P3     = 5;
    localparam int BIT_UNLOCK = 4;
    localparam int BIT_RE     = 3;
    localparam int PRESC_W    = 4;
    localparam int PRESC_MAX  = 9;
    localparam int WIN_CYCLES = 4;
    localparam int WIN_W      = $clog2(WIN_CYCLES + 1);
endpackage

// File: rtl/wdog_regs.sv
// Module: control/status register of the watchdog.
// Holds the interrupt flag (write-one-to-clear, also cleared by acknowledge),
// the interrupt enable, the reset enable and the 4-bit period field.
// The reset enable can be cleared, and the period changed, only inside the
// unlock window. A write with the unlock and reset-enable bits both set
// opens that window.
// Assumes: single-cycle write strobe, synchronous active-low reset.
module wdog_regs
    import wdog_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               re_init,
    input  logic               we,
    input  logic [7:0]         wdata,
    input  logic               set_flag,
    input  logic               ack,
    output logic [7:0]         rdata,
    output logic               flag,
    output logic               ie,
    output logic               re,
    output logic [PRESC_W-1:0] presc,
    output logic               presc_chg
);
    logic [WIN_W-1:0]   win_cnt;
    logic               win_open;
    logic               open_req;
    logic               accept;
    logic [PRESC_W-1:0] presc_new;

    // Decode the window state and the kind of write being made.
    always_comb begin
        win_open  = (win_cnt != '0);
        open_req  = we && wdata[BIT_UNLOCK] && wdata[BIT_RE] && !win_open;
        accept    = we && win_open;
        presc_new = {wdata[BIT_P3], wdata[2:0]};
        presc_chg = accept && (presc_new != presc);
    end

    // Count down the unlock window; it closes early when a write is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)          win_cnt <= '0;
        else if (open_req)   win_cnt <= WIN_W'(WIN_CYCLES);
        else if (accept)     win_cnt <= '0;
        else if (win_open)   win_cnt <= win_cnt - 1'b1;
    end

    // Reset enable: any write may set it, only a write in the window may clear it.
    always_ff @(posedge clk) begin
        if (!rst_n)                    re <= re_init;
        else if (accept)               re <= wdata[BIT_RE];
        else if (we && wdata[BIT_RE])  re <= 1'b1;
    end

    // Period field: changes only through a write in the window.
    always_ff @(posedge clk) begin
        if (!rst_n)       presc <= '0;
        else if (accept)  presc <= presc_new;
    end

    // Interrupt enable: software writes it freely; an acknowledge in combined mode clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                        ie <= 1'b0;
        else if (ack && flag && ie && re)  ie <= 1'b0;
        else if (we)                       ie <= wdata[BIT_IE];
    end

    // Interrupt flag: a timeout sets it, and that wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= set_flag || (flag && !(we && wdata[BIT_FLAG]) && !ack);
    end

    // Read-back packing in register bit order.
    always_comb begin
        rdata = {flag, ie, presc[3], win_open, re, presc[2:0]};
    end

    // R9
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt <= WIN_W'(WIN_CYCLES));

    // R9
    re_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cnt == '0) |=> !$fell(re));

    // R9
    presc_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cnt == '0) |=> $stable(presc));
endmodule

// File: rtl/wdog_counter.sv
// Module: timeout counter of the watchdog.
// Counts oscillator ticks while running. It raises a one-cycle timeout on the
// tick that completes 2^(BASE_LOG2+N) ticks, where N is the period field
// limited to PRESC_MAX. Clear and stop both hold the count at zero.
// Assumes: osc_tick is already synchronous to clk; BASE_LOG2 >= 1.
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               run,
    input  logic               clr,
    input  logic [PRESC_W-1:0] presc,
    output logic               tmo
);
    localparam int CW = BASE_LOG2 + PRESC_MAX + 1;
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    logic [CW-1:0]      cnt;
    logic [CW-1:0]      lim_m1;
    logic [PRESC_W-1:0] nsel;

    // Limit the period field to the longest period and derive the terminal count.
    always_comb begin
        nsel   = (presc > PRESC_W'(PRESC_MAX)) ? PRESC_W'(PRESC_MAX) : presc;
        lim_m1 = (CNT_ONE << (BASE_LOG2 + int'(nsel))) - CNT_ONE;
        tmo    = run && tick && !clr && (cnt == lim_m1);
    end

    // Advance on ticks, wrap at the terminal count, hold zero when stopped or cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clr) cnt <= '0;
        else if (tick)             cnt <= tmo ? '0 : cnt + CNT_ONE;
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim_m1);

    // R8
    stopped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/wdog_timer.sv
// Module: watchdog top level. Joins the register and the counter and decides
// what a timeout does. With the interrupt enable set it raises the flag.
// With only the reset enable set it sends a one-cycle reset request.
// Assumes: the system reset caused by sys_rst_req is applied from outside.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       wd_kick,
    input  logic       gie,
    input  logic       irq_ack,
    input  logic       rst_en_default,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       sys_rst_req
);
    logic               flag;
    logic               ie;
    logic               re;
    logic [PRESC_W-1:0] presc;
    logic               presc_chg;
    logic               tmo;
    logic               set_flag;
    logic               rst_fire;

    // Decide what a timeout does in the current mode.
    always_comb begin
        set_flag = tmo && ie;
        rst_fire = tmo && !ie && re;
        irq      = flag && ie && gie;
    end

    wdog_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .re_init   (rst_en_default),
        .we        (reg_we),
        .wdata     (reg_wdata),
        .set_flag  (set_flag),
        .ack       (irq_ack),
        .rdata     (reg_rdata),
        .flag      (flag),
        .ie        (ie),
        .re        (re),
        .presc     (presc),
        .presc_chg (presc_chg)
    );

    wdog_counter #(.BASE_LOG2(BASE_LOG2)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (osc_tick),
        .run   (ie || re),
        .clr   (wd_kick || presc_chg),
        .presc (presc),
        .tmo   (tmo)
    );

    // Register the reset request so that it is a clean one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) sys_rst_req <= 1'b0;
        else        sys_rst_req <= rst_fire;
    end

    // R4
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tmo && ie));

    // R6
    rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(tmo && !ie && re));

    // R7
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);

    // R8
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie && !re) |=> !sys_rst_req && !$rose(flag));
endmodule

// File: tb/wdog_timer_bench.sv
// Directed bench for the watchdog: one task per scenario, each checking its own results.
module wdog_timer_bench;
    localparam int BASE = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b1;
    logic       wd_kick = 1'b0;
    logic       gie = 1'b0;
    logic       irq_ack = 1'b0;
    logic       rst_en_default = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       sys_rst_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    wdog_timer #(.BASE_LOG2(BASE)) u_wdog_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .osc_tick       (osc_tick),
        .wd_kick        (wd_kick),
        .gie            (gie),
        .irq_ack        (irq_ack),
        .rst_en_default (rst_en_default),
        .reg_we         (reg_we),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .irq            (irq),
        .sys_rst_req    (sys_rst_req)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        reg_we = 1'b1;
        reg_wdata = d;
        step(1);
        reg_we = 1'b0;
    endtask

    task automatic do_reset(input logic init);
        rst_en_default = init;
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    // R1, R8: reset state with reset enable defaulting low, then a stopped watchdog
    task automatic t_reset_stopped();
        int hits;
        do_reset(1'b0);
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 irq", irq, 1'b0);
        chk("R1 rst", sys_rst_req, 1'b0);
        hits = 0;
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (sys_rst_req || reg_rdata[7]) hits++;
        end
        chk("R8 stopped events", hits, 0);
    endtask

    // R1, R7, R2, R9, R8: reset enable defaults high, pulses, then unlock and stop
    task automatic t_reset_mode();
        int hits;
        do_reset(1'b1);
        chk("R1 rdata init1", reg_rdata, 8'h08);
        step(3);
        chk("R7 no pulse early", sys_rst_req, 1'b0);
        step(1);
        chk("R7 pulse", sys_rst_req, 1'b1);
        step(1);
        chk("R7 pulse width", sys_rst_req, 1'b0);
        step(2);
        chk("R7 second early", sys_rst_req, 1'b0);
        step(1);
        chk("R7 second pulse", sys_rst_req, 1'b1);
        wr(8'h18);
        chk("R2 unlock bit", reg_rdata, 8'h18);
        wr(8'h00);
        chk("R9 re cleared in window", reg_rdata, 8'h00);
        step(2);
        hits = 0;
        for (int i = 0; i < 10; i++) begin
            step(1);
            if (sys_rst_req) hits++;
        end
        chk("R8 no reset when stopped", hits, 0);
    endtask

    // R4, R5: interrupt-only mode, gating, flag clearing
    task automatic t_irq_mode();
        gie = 1'b1;
        wr(8'h40);
        step(3);
        chk("R4 flag early", reg_rdata[7], 1'b0);
        step(1);
        chk("R4 flag set", reg_rdata[7], 1'b1);
        chk("R4 irq", irq, 1'b1);
        gie = 1'b0;
        #1;
        chk("R4 irq gated by gie", irq, 1'b0);
        gie = 1'b1;
        wd_kick = 1'b1;
        wr(8'h40);
        chk("R5 write zero keeps flag", reg_rdata, 8'hC0);
        wr(8'hC0);
        chk("R5 w1c", reg_rdata, 8'h40);
        wd_kick = 1'b0;
        step(3);
        chk("R4 flag early again", reg_rdata[7], 1'b0);
        step(1);
        chk("R4 flag again", reg_rdata[7], 1'b1);
        wd_kick = 1'b1;
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
        chk("R5 ack clears flag only", reg_rdata, 8'h40);
    endtask

    // R10, R3: kick restarts the count, ticks gate it
    task automatic t_kick_tick();
        wd_kick = 1'b0;
        step(2);
        wd_kick = 1'b1;
        step(1);
        wd_kick = 1'b0;
        osc_tick = 1'b0;
        step(10);
        chk("R3 no count without ticks", reg_rdata[7], 1'b0);
        osc_tick = 1'b1;
        step(3);
        chk("R10 kick delayed timeout", reg_rdata[7], 1'b0);
        step(1);
        chk("R10 timeout after kick", reg_rdata[7], 1'b1);
        wd_kick = 1'b1;
    endtask

    // R3, R10, R2: period 1 through the unlock sequence
    task automatic t_period_one();
        wr(8'h58);
        wd_kick = 1'b0;
        wr(8'hC1);
        chk("R2 period readback", reg_rdata, 8'h41);
        step(7);
        chk("R3 period1 early", reg_rdata[7], 1'b0);
        step(1);
        chk("R3 period1 timeout", reg_rdata, 8'hC1);
        wd_kick = 1'b1;
    endtask

    // R11, R2: reserved period value behaves like 9
    task automatic t_period_reserved();
        wr(8'h58);
        wd_kick = 1'b0;
        wr(8'hE4);
        chk("R2 bit5 position", reg_rdata, 8'h64);
        step(2047);
        chk("R11 reserved early", reg_rdata[7], 1'b0);
        step(1);
        chk("R11 reserved timeout", reg_rdata[7], 1'b1);
        wd_kick = 1'b1;
    endtask

    // R9: window expiry and last-cycle acceptance
    task automatic t_window();
        wr(8'hD8);
        chk("R9 window open", reg_rdata, 8'h7C);
        step(4);
        chk("R9 window expired", reg_rdata, 8'h6C);
        wr(8'h40);
        chk("R9 locked write ignored", reg_rdata, 8'h6C);
        wr(8'h58);
        chk("R9 reopen", reg_rdata, 8'h7C);
        step(3);
        wr(8'h40);
        chk("R9 fourth cycle accepted", reg_rdata, 8'h40);
    endtask

    // R6: combined mode, interrupt first then reset
    task automatic t_combined();
        wr(8'h18);
        chk("R9 open from irq mode", reg_rdata, 8'h18);
        wr(8'hC8);
        chk("R6 combined set", reg_rdata, 8'h48);
        gie = 1'b1;
        wd_kick = 1'b0;
        step(3);
        chk("R6 flag early", reg_rdata[7], 1'b0);
        step(1);
        chk("R6 first timeout irq", irq, 1'b1);
        chk("R6 first timeout no reset", sys_rst_req, 1'b0);
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
        chk("R6 ack clears flag and ie", reg_rdata, 8'h08);
        chk("R6 irq low", irq, 1'b0);
        step(2);
        chk("R6 reset early", sys_rst_req, 1'b0);
        step(1);
        chk("R6 reset request", sys_rst_req, 1'b1);
        step(1);
        chk("R7 combined pulse width", sys_rst_req, 1'b0);
    endtask

    initial begin
        #1;
        t_reset_stopped();
        t_reset_mode();
        t_irq_mode();
        t_kick_tick();
        t_period_one();
        t_period_reserved();
        t_window();
        t_combined();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule